// File: doc/BRIEF.md
# Range Invariant Violation Checker

This block holds a bank of value-range monitors, one for each invariant. A producer presents a sample as an invariant index and a signed value with a strobe. Each invariant slot keeps a lower bound, an upper bound, a trained flag and a disabled flag. While the controller is in its learning state, samples widen the bounds of their slot. Running learning several times merges all the ranges seen into one range for each invariant. While the controller is in its watching state, a sample outside its slot's range raises a one-cycle violation pulse. The pulse carries the index and the value, and a diagnosis agent uses it as a detection symptom.

When the agent judges a violation to be a false positive, it sends a disable command for that index. From then on the slot stays silent until the whole bank is wiped. A wipe command returns every slot to the untrained state and clears every disable flag.

The mode controller has three states. IDLE ignores samples. LEARN trains the bounds. WATCH checks samples. Each cycle the controller takes the transition that the mode request selects, so any state can move to any other. The named transitions are open (to LEARN), arm (to WATCH) and park (to IDLE). A wipe forces park for one cycle.

Top module: `rng_inv_guard`

## Requirements
- R1: After reset `viol_vld` is low, every slot is untrained and the controller is in IDLE.
- R2: The first sample learned by an untrained slot sets both bounds to that value. In WATCH only that exact value then passes.
- R3: A later learned sample moves only the bound it exceeds. A sample inside the range changes nothing.
- R4: Bounds persist when the controller leaves LEARN, so separate learning runs merge into one range.
- R5: In WATCH, a sample for a trained, enabled slot passes when lower <= value <= upper, compared as signed numbers. Any other value sets `viol_vld` for exactly the one cycle after the strobe, with `viol_idx` and `viol_val` equal to the sample's index and value.
- R6: An untrained slot never raises a violation.
- R7: After `dis_vld` is given for index i, slot i never raises a violation until a wipe. Other slots keep checking.
- R8: `wipe_all` returns every slot to untrained, clears every disable flag and puts the controller in IDLE on the next cycle. A sample in the wipe cycle is ignored.
- R9: No violation is raised outside WATCH. Samples in IDLE leave the bounds unchanged.
- R10: `mode_req` 2'b01 selects LEARN, 2'b10 selects WATCH, and 2'b00 or 2'b11 selects IDLE. The new state applies to samples from the cycle after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 2 | Requested mode (R10 encoding) |
| wipe_all | input | 1 | Return all slots to untrained |
| smp_vld | input | 1 | Sample strobe |
| smp_idx | input | IDX_W | Invariant index of the sample |
| smp_val | input | VAL_W | Signed sample value |
| dis_vld | input | 1 | Disable command strobe |
| dis_idx | input | IDX_W | Invariant to disable |
| viol_vld | output | 1 | One-cycle violation pulse |
| viol_idx | output | IDX_W | Index of the invariant that fired |
| viol_val | output | VAL_W | Offending value |

## Verification
The assertions assume that inputs are known after reset and that every index is below NUM_INV. They also assume that a disable command and a sample for the same slot never arrive in the same cycle. The bench keeps within these limits. It drives one command at a time on the falling edge, uses only indices 0 to 3 of a four-slot, 8-bit build, and leaves a full clock between a disable and the next sample. In that build every value from -128 to 127 is swept against each slot, so the exact pass window can be computed arithmetically.

// File: rtl/rig_pkg.sv
package rig_pkg;

    typedef enum logic [1:0] {
        RIG_IDLE  = 2'd0,
        RIG_LEARN = 2'd1,
        RIG_WATCH = 2'd2
    } rig_state_e;

    localparam logic [1:0] MODE_LEARN = 2'b01;
    localparam logic [1:0] MODE_WATCH = 2'b10;

endpackage

// File: rtl/rig_mode_fsm.sv
module rig_mode_fsm
    import rig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wipe,
    input  logic [1:0] mode_req,
    output rig_state_e cur_st,
    output logic       learn_on,
    output logic       watch_on
);

    rig_state_e req_st;
    rig_state_e nxt_st;

    // decode the requested mode
    always_comb begin
        unique case (mode_req)
            MODE_LEARN: req_st = RIG_LEARN;
            MODE_WATCH: req_st = RIG_WATCH;
            default:    req_st = RIG_IDLE;
        endcase
    end

    // transitions: open -> LEARN, arm -> WATCH, park -> IDLE (wipe forces park)
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            RIG_IDLE:  nxt_st = wipe ? RIG_IDLE : req_st;
            RIG_LEARN: nxt_st = wipe ? RIG_IDLE : req_st;
            RIG_WATCH: nxt_st = wipe ? RIG_IDLE : req_st;
            default:   nxt_st = RIG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cur_st <= RIG_IDLE;
        else        cur_st <= nxt_st;
    end

    // outputs
    always_comb begin
        learn_on = 1'b0;
        watch_on = 1'b0;
        unique case (cur_st)
            RIG_LEARN: learn_on = 1'b1;
            RIG_WATCH: watch_on = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rig_slot.sv
module rig_slot #(
    parameter int VAL_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wipe,
    input  logic                    learn_hit,
    input  logic                    dis_hit,
    input  logic signed [VAL_W-1:0] probe,
    output logic                    trained,
    output logic                    muted,
    output logic signed [VAL_W-1:0] lo,
    output logic signed [VAL_W-1:0] hi,
    output logic                    out_of_range
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trained <= 1'b0;
            muted   <= 1'b0;
            lo      <= '0;
            hi      <= '0;
        end else if (wipe) begin
            trained <= 1'b0;
            muted   <= 1'b0;
        end else begin
            if (learn_hit) begin
                if (!trained) begin
                    trained <= 1'b1;
                    lo      <= probe;
                    hi      <= probe;
                end else if (probe < lo) begin
                    lo <= probe;
                end else if (probe > hi) begin
                    hi <= probe;
                end
            end
            if (dis_hit) muted <= 1'b1;
        end
    end

    assign out_of_range = trained && !muted && ((probe < lo) || (probe > hi));

endmodule

// File: rtl/rng_inv_guard.sv
module rng_inv_guard
    import rig_pkg::*;
#(
    parameter int NUM_INV = 8,
    parameter int VAL_W   = 32,
    localparam int IDX_W  = (NUM_INV > 1) ? $clog2(NUM_INV) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_req,
    input  logic                    wipe_all,
    input  logic                    smp_vld,
    input  logic [IDX_W-1:0]        smp_idx,
    input  logic signed [VAL_W-1:0] smp_val,
    input  logic                    dis_vld,
    input  logic [IDX_W-1:0]        dis_idx,
    output logic                    viol_vld,
    output logic [IDX_W-1:0]        viol_idx,
    output logic signed [VAL_W-1:0] viol_val
);

    rig_state_e cur_st;
    logic       learn_on;
    logic       watch_on;

    logic [NUM_INV-1:0]            slot_valid;
    logic [NUM_INV-1:0]            slot_dis;
    logic [NUM_INV-1:0]            oor;
    logic [NUM_INV-1:0][VAL_W-1:0] lo_all;
    logic [NUM_INV-1:0][VAL_W-1:0] hi_all;

    logic idx_ok;
    logic fire;

    rig_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (wipe_all),
        .mode_req (mode_req),
        .cur_st   (cur_st),
        .learn_on (learn_on),
        .watch_on (watch_on)
    );

    for (genvar g = 0; g < NUM_INV; g++) begin : g_slot
        logic lhit;
        logic dhit;
        assign lhit = learn_on && smp_vld && (smp_idx == IDX_W'(g));
        assign dhit = dis_vld && (dis_idx == IDX_W'(g));
        rig_slot #(.VAL_W(VAL_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .wipe         (wipe_all),
            .learn_hit    (lhit),
            .dis_hit      (dhit),
            .probe        (smp_val),
            .trained      (slot_valid[g]),
            .muted        (slot_dis[g]),
            .lo           (lo_all[g]),
            .hi           (hi_all[g]),
            .out_of_range (oor[g])
        );
    end

    assign idx_ok = ({1'b0, smp_idx} < (IDX_W+1)'(NUM_INV));
    assign fire   = watch_on && smp_vld && idx_ok && !wipe_all && oor[smp_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_vld <= 1'b0;
            viol_idx <= '0;
            viol_val <= '0;
        end else begin
            viol_vld <= fire;
            if (fire) begin
                viol_idx <= smp_idx;
                viol_val <= smp_val;
            end
        end
    end

endmodule

// File: rtl/rig_guard_chk.sv
module rig_guard_chk
    import rig_pkg::*;
#(
    parameter int NUM_INV = 8,
    parameter int VAL_W   = 32,
    localparam int IDX_W  = (NUM_INV > 1) ? $clog2(NUM_INV) : 1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wipe_all,
    input logic                            smp_vld,
    input logic [IDX_W-1:0]                smp_idx,
    input logic [VAL_W-1:0]                smp_val,
    input logic                            viol_vld,
    input logic [IDX_W-1:0]                viol_idx,
    input logic [VAL_W-1:0]                viol_val,
    input logic                            watch_on,
    input rig_state_e                      cur_st,
    input logic [NUM_INV-1:0]              slot_ok,
    input logic [NUM_INV-1:0]              slot_off,
    input logic [NUM_INV-1:0][VAL_W-1:0]   lo_all,
    input logic [NUM_INV-1:0][VAL_W-1:0]   hi_all
);

    a_r5_pulse_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        viol_vld |-> $past(smp_vld && watch_on && !wipe_all));

    a_r5_carries_sample: assert property (@(posedge clk) disable iff (!rst_n)
        viol_vld |-> (viol_idx == $past(smp_idx)) && (viol_val == $past(smp_val)));

    a_r5_value_outside: assert property (@(posedge clk) disable iff (!rst_n)
        viol_vld |-> (($signed(viol_val) < $signed($past(lo_all[smp_idx])))
                   || ($signed(viol_val) > $signed($past(hi_all[smp_idx])))));

    a_r6_trained_only: assert property (@(posedge clk) disable iff (!rst_n)
        viol_vld |-> $past(slot_ok[smp_idx]));

    a_r7_not_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        viol_vld |-> !$past(slot_off[smp_idx]));

    a_r8_wipe_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_all |=> (cur_st == RIG_IDLE) && (slot_ok == '0) && (slot_off == '0) && !viol_vld);

    a_r9_quiet_outside_watch: assert property (@(posedge clk) disable iff (!rst_n)
        !watch_on |=> !viol_vld);

    for (genvar i = 0; i < NUM_INV; i++) begin : g_order
        a_r3_lo_not_above_hi: assert property (@(posedge clk) disable iff (!rst_n)
            slot_ok[i] |-> ($signed(lo_all[i]) <= $signed(hi_all[i])));
    end

endmodule

bind rng_inv_guard rig_guard_chk #(.NUM_INV(NUM_INV), .VAL_W(VAL_W)) u_rig_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wipe_all (wipe_all),
    .smp_vld  (smp_vld),
    .smp_idx  (smp_idx),
    .smp_val  (smp_val),
    .viol_vld (viol_vld),
    .viol_idx (viol_idx),
    .viol_val (viol_val),
    .watch_on (watch_on),
    .cur_st   (cur_st),
    .slot_ok  (slot_valid),
    .slot_off (slot_dis),
    .lo_all   (lo_all),
    .hi_all   (hi_all)
);

// File: tb/tb_rng_inv_guard.sv
module tb_rng_inv_guard;

    localparam int N  = 4;
    localparam int VW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_req = 2'b00;
    logic              wipe_all = 1'b0;
    logic              smp_vld = 1'b0;
    logic [1:0]        smp_idx = '0;
    logic signed [7:0] smp_val = '0;
    logic              dis_vld = 1'b0;
    logic [1:0]        dis_idx = '0;
    logic              viol_vld;
    logic [1:0]        viol_idx;
    logic signed [7:0] viol_val;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int lo[N];
    int hi[N];
    bit tv[N];
    bit dz[N];
    int md = 0;

    always #4 clk = ~clk;

    rng_inv_guard #(.NUM_INV(N), .VAL_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .wipe_all(wipe_all),
        .smp_vld(smp_vld), .smp_idx(smp_idx), .smp_val(smp_val),
        .dis_vld(dis_vld), .dis_idx(dis_idx),
        .viol_vld(viol_vld), .viol_idx(viol_idx), .viol_val(viol_val)
    );

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_req = m;
        @(negedge clk);
        md = (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 0;
    endtask

    task automatic push(input int idx, input int v, input string tag);
        bit exp;
        @(negedge clk);
        smp_vld = 1'b1;
        smp_idx = 2'(idx);
        smp_val = 8'(v);
        exp = (md == 2) && tv[idx] && !dz[idx] && ((v < lo[idx]) || (v > hi[idx]));
        if (md == 1) begin
            if (!tv[idx]) begin
                tv[idx] = 1; lo[idx] = v; hi[idx] = v;
            end else if (v < lo[idx]) lo[idx] = v;
            else if (v > hi[idx]) hi[idx] = v;
        end
        @(negedge clk);
        smp_vld = 1'b0;
        n_chk++;
        if (viol_vld !== exp ||
            (exp && (viol_idx !== 2'(idx) || int'(viol_val) != v))) begin
            n_fail++;
            $display("FAIL %s: slot %0d value %0d got vld=%b idx=%0d val=%0d expected vld=%b idx=%0d val=%0d",
                     tag, idx, v, viol_vld, viol_idx, viol_val, exp, idx, v);
        end
    endtask

    task automatic sweep(input int idx, input string tag);
        for (int v = -128; v <= 127; v++) push(idx, v, tag);
    endtask

    task automatic quiet(input string tag);
        @(negedge clk);
        n_chk++;
        if (viol_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: viol_vld=%b expected 0", tag, viol_vld);
        end
    endtask

    task automatic kill(input int idx);
        @(negedge clk);
        dis_vld = 1'b1;
        dis_idx = 2'(idx);
        @(negedge clk);
        dis_vld = 1'b0;
        dz[idx] = 1;
    endtask

    task automatic wipe();
        @(negedge clk);
        wipe_all = 1'b1;
        mode_req = 2'b00;
        smp_vld = 1'b1;
        smp_idx = 2'd0;
        smp_val = 8'sd99;
        @(negedge clk);
        wipe_all = 1'b0;
        smp_vld = 1'b0;
        md = 0;
        for (int i = 0; i < N; i++) begin tv[i] = 0; dz[i] = 0; end
        n_chk++;
        if (viol_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R8: viol_vld=%b during wipe expected 0", viol_vld);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin tv[i] = 0; dz[i] = 0; lo[i] = 0; hi[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        quiet("R1 reset");

        // R1 / R6: untrained slots silent in WATCH
        set_mode(2'b10);
        sweep(0, "R1 untrained after reset");
        sweep(3, "R6 untrained slot");

        // R2: single learned value
        set_mode(2'b01);
        push(0, 10, "R9 learn quiet");
        set_mode(2'b10);
        sweep(0, "R2 single value range");

        // R3: widening
        set_mode(2'b01);
        push(0, 20, "R9 learn quiet");
        push(0, -5, "R9 learn quiet");
        push(0, 15, "R9 learn quiet");
        push(1, -100, "R9 learn quiet");
        push(1, 100, "R9 learn quiet");
        push(2, -128, "R9 learn quiet");
        set_mode(2'b10);
        sweep(0, "R3 widened bounds");
        sweep(1, "R5 signed range");
        sweep(2, "R5 minimum value range");
        sweep(3, "R6 untrained slot");

        // R9 / R10: IDLE via 00 and 11 ignores samples
        set_mode(2'b00);
        push(0, 50, "R9 idle quiet");
        set_mode(2'b11);
        push(0, -60, "R10 mode 11 is idle");
        // R4: second learning run merges
        set_mode(2'b01);
        push(0, 40, "R9 learn quiet");
        set_mode(2'b10);
        sweep(0, "R4 merged runs");

        // R5: one-cycle pulse
        push(0, 127, "R5 violation");
        quiet("R5 pulse lasts one cycle");

        // R7: disable
        kill(1);
        sweep(1, "R7 disabled slot silent");
        sweep(0, "R7 other slot still checks");

        // R8: wipe
        wipe();
        quiet("R8 idle after wipe");
        set_mode(2'b10);
        sweep(0, "R8 slot untrained after wipe");
        sweep(1, "R8 slot untrained after wipe");
        set_mode(2'b01);
        push(1, 7, "R9 learn quiet");
        set_mode(2'b10);
        sweep(1, "R8 disable cleared by wipe");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule